// File: doc/BRIEF.md
# Sensor Pixel Scan Controller

This block sequences the capture of one image from a passive 30-row by 40-column sensor array, one pixel at a time. For every pixel it presents a 5-bit row address to an external 32:1 analog multiplexer and a 6-bit column address to a bank of three 16:1 column multiplexers. The low four column bits go to all three column multiplexers in parallel. The upper two column bits are decoded into active-low enables, so that only the multiplexer carrying the addressed column drives the shared analog line.

Once the addresses for a pixel have been held for a programmable settle time, the controller pulses a conversion start to an external ADC. It then waits for the ADC's completion strobe and writes the 12-bit result, left-aligned in a 16-bit word, into the active half of a ping-pong frame buffer. After the write it moves the addresses to the next pixel and starts the settle timer again.

After the last pixel has been written, the controller raises a frame-done flag and stays idle. A consumer issues a swap/start command, which flips the active bank, clears the flag and starts the next scan. The consumer can therefore process the bank that was just filled while the other bank is being filled.

Top module: `pixel_scan_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `frame_done`, `adc_start` and `buf_we` are 0, `row_addr` and `col_addr` are 0, and `buf_bank` is 0.
- R2: Pixels are visited in row-major order. The column runs 0..39 fastest, then the row advances, over rows 0..29, and each frame begins at row 0, column 0.
- R3: `mux_en_n` is active low. Bit k is 0 exactly when `col_addr[5:4]` equals k: columns 0–15 select bit 0, columns 16–31 select bit 1, and columns 32–39 select bit 2. Exactly one bit is low at all times.
- R4: `adc_start` is a single-cycle pulse. It rises `settle_cycles`+1 clock cycles after the edge that changed the pixel address or started the frame.
- R5: A completion strobe `adc_done` accepted while a conversion is pending produces exactly one `buf_we` pulse in the following cycle, with `buf_addr` = row*40 + column of the converted pixel.
- R6: `buf_wdata` holds the 12-bit sample in bits 15:4 with bits 3:0 zero (left-aligned, no offset).
- R7: When pixel 1199 (row 29, column 39) is written, `frame_done` rises in the same cycle as `buf_we`, `busy` drops, and no further `adc_start` pulse occurs until the next swap/start.
- R8: A `swap_start` pulse while idle toggles `buf_bank`, clears `frame_done`, resets the addresses to pixel 0 and sets `busy`. The first frame after reset therefore fills bank 1.
- R9: A `swap_start` pulse while a frame is in progress is ignored: `buf_bank` and the scan sequence are unchanged.
- R10: An `adc_done` pulse while no conversion is pending (during settling or idle) is ignored and causes no buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_start | input | 1 | Consumer command: swap bank and start a frame (honoured only while idle) |
| settle_cycles | input | 8 | Settle delay N between address change and conversion start |
| adc_done | input | 1 | ADC conversion-complete strobe |
| adc_data | input | 12 | ADC sample, valid with adc_done |
| row_addr | output | 5 | Row multiplexer address |
| col_addr | output | 6 | Column address; low 4 bits shared by the column multiplexers |
| mux_en_n | output | 3 | Active-low enable per column multiplexer |
| adc_start | output | 1 | One-cycle conversion start pulse |
| buf_we | output | 1 | Frame buffer write strobe |
| buf_bank | output | 1 | Active buffer bank |
| buf_addr | output | 11 | Frame buffer word address (row*40+column) |
| buf_wdata | output | 16 | Left-aligned sample word |
| busy | output | 1 | A frame scan is in progress |
| frame_done | output | 1 | Last pixel of the frame has been stored |

## Verification
The checker watches several properties on every cycle. It confirms that the addresses stay within 30 rows and 40 columns and that exactly one column enable is low. It confirms that the addresses do not move when a conversion starts, that each write address matches the row and column just converted, and that each stored word has zero low bits. It also confirms that the bank toggles only when a frame starts and that nothing starts once the frame is done. Other properties need the bench's scenarios. These are the full row-major visiting order, the exact settle interval for several `settle_cycles` values, the sample-to-word mapping, and the ignoring of stray completion strobes and of swap commands issued mid-frame. The bench shows these by sweeping every pixel of three whole frames with different settle delays.

// File: rtl/pixscan_pkg.sv
package pixscan_pkg;

    localparam int ROWS     = 30;
    localparam int COLS     = 40;
    localparam int ROW_W    = 5;
    localparam int COL_W    = 6;
    localparam int SEL_LO_W = 4;
    localparam int NUM_MUX  = 3;
    localparam int SAMPLE_W = 12;
    localparam int WORD_W   = 16;
    localparam int PIXELS   = ROWS * COLS;
    localparam int IDX_W    = $clog2(PIXELS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_WAIT
    } scan_state_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [IDX_W-1:0] idx;
    } pix_pos_t;

    function automatic logic [WORD_W-1:0] align_left(input logic [SAMPLE_W-1:0] s);
        return {s, {(WORD_W-SAMPLE_W){1'b0}}};
    endfunction

endpackage

// File: rtl/pixscan_addr_gen.sv
module pixscan_addr_gen
    import pixscan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     advance,
    output pix_pos_t pos,
    output logic     last
);

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos <= '0;
        end else if (advance) begin
            pos.idx <= pos.idx + 1'b1;
            if (pos.col == COL_LAST) begin
                pos.col <= '0;
                pos.row <= pos.row + 1'b1;
            end else begin
                pos.col <= pos.col + 1'b1;
            end
        end
    end

    assign last = (pos.row == ROW_LAST) && (pos.col == COL_LAST);

endmodule

// File: rtl/pixscan_mux_decode.sv
module pixscan_mux_decode #(
    parameter int COL_W    = 6,
    parameter int SEL_LO_W = 4,
    parameter int NUM_MUX  = 3
) (
    input  logic [COL_W-1:0]   col,
    output logic [NUM_MUX-1:0] en_n
);

    localparam int HI_W = COL_W - SEL_LO_W;

    logic [HI_W-1:0] hi_sel;
    assign hi_sel = col[COL_W-1:SEL_LO_W];

    for (genvar k = 0; k < NUM_MUX; k++) begin : g_en
        assign en_n[k] = (hi_sel != HI_W'(k));
    end

endmodule

// File: rtl/pixel_scan_ctrl.sv
module pixel_scan_ctrl
    import pixscan_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                swap_start,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                adc_done,
    input  logic [SAMPLE_W-1:0] adc_data,
    output logic [ROW_W-1:0]    row_addr,
    output logic [COL_W-1:0]    col_addr,
    output logic [NUM_MUX-1:0]  mux_en_n,
    output logic                adc_start,
    output logic                buf_we,
    output logic                buf_bank,
    output logic [IDX_W-1:0]    buf_addr,
    output logic [WORD_W-1:0]   buf_wdata,
    output logic                busy,
    output logic                frame_done
);

    scan_state_e         state;
    logic [SETTLE_W-1:0] settle_cnt;
    pix_pos_t            pos;
    logic                pos_last;
    logic                pos_clear;
    logic                pos_adv;

    assign pos_clear = (state == ST_IDLE) && swap_start;
    assign pos_adv   = (state == ST_WAIT) && adc_done && !pos_last;

    pixscan_addr_gen u_addr (
        .clk     (clk),
        .rst     (rst),
        .clear   (pos_clear),
        .advance (pos_adv),
        .pos     (pos),
        .last    (pos_last)
    );

    pixscan_mux_decode #(
        .COL_W    (COL_W),
        .SEL_LO_W (SEL_LO_W),
        .NUM_MUX  (NUM_MUX)
    ) u_dec (
        .col  (pos.col),
        .en_n (mux_en_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            settle_cnt <= '0;
            adc_start  <= 1'b0;
            buf_we     <= 1'b0;
            buf_bank   <= 1'b0;
            buf_addr   <= '0;
            buf_wdata  <= '0;
            frame_done <= 1'b0;
        end else begin
            adc_start <= 1'b0;
            buf_we    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (swap_start) begin
                        buf_bank   <= ~buf_bank;
                        frame_done <= 1'b0;
                        settle_cnt <= '0;
                        state      <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == settle_cycles) begin
                        adc_start <= 1'b1;
                        state     <= ST_WAIT;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (adc_done) begin
                        buf_we    <= 1'b1;
                        buf_addr  <= pos.idx;
                        buf_wdata <= align_left(adc_data);
                        if (pos_last) begin
                            frame_done <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            settle_cnt <= '0;
                            state      <= ST_SETTLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign row_addr = pos.row;
    assign col_addr = pos.col;
    assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/pixel_scan_ctrl_chk.sv
module pixel_scan_ctrl_chk
    import pixscan_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                adc_done,
    input logic [ROW_W-1:0]    row_addr,
    input logic [COL_W-1:0]    col_addr,
    input logic [NUM_MUX-1:0]  mux_en_n,
    input logic                adc_start,
    input logic                buf_we,
    input logic                buf_bank,
    input logic [IDX_W-1:0]    buf_addr,
    input logic [WORD_W-1:0]   buf_wdata,
    input logic                busy,
    input logic                frame_done
);

    assert_addr_range_R2: assert property (@(posedge clk) disable iff (rst)
        (int'(row_addr) < ROWS) && (int'(col_addr) < COLS));

    assert_one_enable_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(~mux_en_n) == 1);

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    assert_start_addr_stable_R4: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> ($stable(row_addr) && $stable(col_addr) && busy));

    assert_write_addr_R5: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (int'(buf_addr) == int'($past(row_addr)) * COLS + int'($past(col_addr))));

    assert_write_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> $past(adc_done));

    assert_left_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (buf_wdata[WORD_W-SAMPLE_W-1:0] == '0));

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!busy && !adc_start));

    assert_bank_toggle_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (buf_bank != $past(buf_bank)));

    assert_bank_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(buf_bank));

endmodule

bind pixel_scan_ctrl pixel_scan_ctrl_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .adc_done   (adc_done),
    .row_addr   (row_addr),
    .col_addr   (col_addr),
    .mux_en_n   (mux_en_n),
    .adc_start  (adc_start),
    .buf_we     (buf_we),
    .buf_bank   (buf_bank),
    .buf_addr   (buf_addr),
    .buf_wdata  (buf_wdata),
    .busy       (busy),
    .frame_done (frame_done)
);

// File: tb/pixel_scan_ctrl_tb.sv
module pixel_scan_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        swap_start = 1'b0;
    logic [7:0]  settle_cycles = 8'd0;
    logic        adc_done = 1'b0;
    logic [11:0] adc_data = 12'd0;
    logic [4:0]  row_addr;
    logic [5:0]  col_addr;
    logic [2:0]  mux_en_n;
    logic        adc_start;
    logic        buf_we;
    logic        buf_bank;
    logic [10:0] buf_addr;
    logic [15:0] buf_wdata;
    logic        busy;
    logic        frame_done;

    int checks = 0;
    int fails  = 0;
    logic exp_bank = 1'b0;

    always #2 clk = ~clk;

    pixel_scan_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .swap_start    (swap_start),
        .settle_cycles (settle_cycles),
        .adc_done      (adc_done),
        .adc_data      (adc_data),
        .row_addr      (row_addr),
        .col_addr      (col_addr),
        .mux_en_n      (mux_en_n),
        .adc_start     (adc_start),
        .buf_we        (buf_we),
        .buf_bank      (buf_bank),
        .buf_addr      (buf_addr),
        .buf_wdata     (buf_wdata),
        .busy          (busy),
        .frame_done    (frame_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // settle interval monitor: cycles since the last address change or frame start
    logic [4:0] prev_row = '0;
    logic [5:0] prev_col = '0;
    logic       prev_busy = 1'b0;
    int         since_chg = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if ((row_addr != prev_row) || (col_addr != prev_col) || (busy && !prev_busy))
                since_chg = 0;
            else
                since_chg++;
            if (adc_start)
                check(since_chg == int'(settle_cycles) + 1, "R4 settle interval",
                      since_chg, int'(settle_cycles) + 1);
        end
        prev_row  = row_addr;
        prev_col  = col_addr;
        prev_busy = busy;
    end

    function automatic logic [2:0] exp_en_n(input int col);
        logic [2:0] e = 3'b111;
        e[col / 16] = 1'b0;
        return e;
    endfunction

    task automatic wait_start();
        do @(negedge clk); while (!adc_start);
    endtask

    task automatic run_frame(input int fr, input logic [7:0] n);
        settle_cycles = n;
        @(negedge clk);
        swap_start = 1'b1;
        @(negedge clk);
        swap_start = 1'b0;
        exp_bank = ~exp_bank;
        check(busy == 1'b1 && frame_done == 1'b0, "R8 start flags", int'({busy, frame_done}), 2);
        check(row_addr == 5'd0 && col_addr == 6'd0, "R8 start at pixel 0",
              int'(row_addr) * 40 + int'(col_addr), 0);
        check(buf_bank == exp_bank, "R8 bank toggle", int'(buf_bank), int'(exp_bank));
        for (int idx = 0; idx < 1200; idx++) begin
            logic [11:0] smp;
            smp = 12'((idx * 7 + fr * 13 + (idx >> 3)) & 12'hFFF);
            wait_start();
            check(row_addr == 5'(idx / 40) && col_addr == 6'(idx % 40), "R2 scan order",
                  int'(row_addr) * 40 + int'(col_addr), idx);
            check(mux_en_n == exp_en_n(idx % 40), "R3 mux enables",
                  int'(mux_en_n), int'(exp_en_n(idx % 40)));
            if (idx == 5) begin
                swap_start = 1'b1;
                @(negedge clk);
                swap_start = 1'b0;
            end
            @(negedge clk);
            adc_done = 1'b1;
            adc_data = smp;
            @(negedge clk);
            adc_done = 1'b0;
            check(buf_we == 1'b1, "R5 write strobe", int'(buf_we), 1);
            check(int'(buf_addr) == idx, "R5 write address", int'(buf_addr), idx);
            check(buf_wdata == {smp, 4'b0000}, "R6 aligned word", int'(buf_wdata), int'({smp, 4'b0000}));
            check(buf_bank == exp_bank, "R9 bank held mid-frame", int'(buf_bank), int'(exp_bank));
            if (idx == 1199) begin
                check(frame_done == 1'b1 && busy == 1'b0, "R7 frame done",
                      int'({frame_done, busy}), 2);
            end else begin
                check(frame_done == 1'b0, "R7 no early done", int'(frame_done), 0);
            end
            if (idx == 7 && n >= 2) begin
                adc_done = 1'b1;
                @(negedge clk);
                adc_done = 1'b0;
                check(buf_we == 1'b0, "R10 stray done in settle", int'(buf_we), 0);
            end
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(adc_start == 1'b0 && frame_done == 1'b1, "R7 quiet after frame",
                  int'({adc_start, frame_done}), 1);
        end
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        @(negedge clk);
        check(buf_we == 1'b0, "R10 stray done while idle", int'(buf_we), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && frame_done == 1'b0 && adc_start == 1'b0 && buf_we == 1'b0,
              "R1 reset flags", int'({busy, frame_done, adc_start, buf_we}), 0);
        check(row_addr == 5'd0 && col_addr == 6'd0, "R1 reset address",
              int'(row_addr) * 40 + int'(col_addr), 0);
        check(buf_bank == 1'b0, "R1 reset bank", int'(buf_bank), 0);
        check(mux_en_n == 3'b110, "R3 reset enables", int'(mux_en_n), 6);
        run_frame(0, 8'd0);
        run_frame(1, 8'd3);
        run_frame(2, 8'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule